// File: doc/BRIEF.md
# Per-Drive Media Change Tracker

This block keeps one media-change flag for each of four disk drives and shows the flag of the selected drive in the top bit of an eight-bit input-register byte. A pulse on a drive's door-event line sets that drive's flag. The flag clears only when a successful head movement on that drive ends on a cylinder that differs from the one the heads were already on. To make that decision, the block keeps a present-cylinder value for each drive. Head-stepping timing is not modelled. A movement arrives as a single completion pulse that carries the drive number, a seek/recalibrate flag, a target cylinder and a success flag.

The host selects a drive and sets that drive's motor bit. It then samples the byte while it raises a read strobe. A selection change does not show at once. For the first few reads after the change, the byte still reports the previously shown drive, and the new drive appears from a read number that a parameter sets. While the selected drive's motor bit is off, the change bit reads as 0.

Top module: `disk_change_tracker`

## Requirements
- R1: `dirByte[7]` is the change flag of the shown drive, gated by the selected drive's motor bit. `dirByte[6:0]` is always 0. The byte is combinational and valid in the same cycle as `rdStrobe`.
- R2: A one-cycle pulse on `doorEvt[d]` sets the flag of drive d from the next cycle. If it coincides with a clearing movement on the same drive, the flag ends set.
- R3: A completed (`moveDone`=1), successful (`moveOk`=1) seek (`moveIsRecal`=0) to a cylinder other than the drive's present cylinder clears that drive's flag. The target then becomes the present cylinder.
- R4: A successful seek to the drive's present cylinder leaves the flag set.
- R5: A successful recalibrate (`moveIsRecal`=1, `moveCyl` ignored) targets cylinder 0. It clears the flag only if the present cylinder was not 0, and it leaves the present cylinder at 0.
- R6: A failed movement (`moveOk`=0) changes neither the flag nor the present cylinder.
- R7: A movement or door event on one drive leaves the flags and cylinders of the other drives unchanged.
- R8: While `motorEn[selDrive]` is 0, `dirByte[7]` is 0 regardless of the flag.
- R9: After `selDrive` changes, reads 1 to SETTLE_READS-1 still report the previously shown drive. From read SETTLE_READS onward, the new drive is reported. The shown drive changes only on a selection change or a read.
- R10: While `rstN` is low, all flags and all present cylinders become 0 and the shown drive becomes drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset |
| doorEvt | input | 4 | Door open/close pulse, one per drive |
| selDrive | input | 2 | Selected drive number |
| motorEn | input | 4 | Motor-enable bit, one per drive |
| rdStrobe | input | 1 | High during a read of the input-register byte |
| moveDone | input | 1 | Head movement completion pulse |
| moveDrive | input | 2 | Drive the movement applies to |
| moveIsRecal | input | 1 | 1 for recalibrate, 0 for seek |
| moveCyl | input | CYL_W | Seek target cylinder |
| moveOk | input | 1 | Movement succeeded |
| dirByte | output | 8 | Input-register byte, change flag in bit 7 |

## Verification
The bench builds the block with CYL_W=3 and SETTLE_READS=5. A cylinder value therefore has only eight states, and the sweep can cover every target cylinder, for both movement kinds and both outcomes, on every drive. Seeks to the same cylinder and to a new cylinder, and recalibrates from cylinder 0 and from a nonzero cylinder, all occur naturally in this sweep. Five settling reads keep the stale-read window short enough to check read by read, and a mid-run reset shows that the present cylinders return to 0.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int NUM_DRIVES = 4;
  localparam int SEL_W = $clog2(NUM_DRIVES);

  typedef struct packed {
    logic [NUM_DRIVES-1:0] moveHit;
    logic                  showLoad;
  } dcStrobe_t;
endpackage

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int SETTLE_READS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selDrive,
  input  logic             rdStrobe,
  input  logic             moveDone,
  input  logic [SEL_W-1:0] moveDrive,
  input  logic             moveOk,
  output dcStrobe_t        strobes
);
  logic [SEL_W-1:0] prevSel;
  logic             selChange;
  logic             showLoad;

  assign selChange = (selDrive != prevSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSel <= '0;
    else       prevSel <= selDrive;
  end

  generate
    if (SETTLE_READS <= 1) begin : g_immediate
      assign showLoad = selChange;
    end else begin : g_settle
      localparam int CNT_W = $clog2(SETTLE_READS);
      logic [CNT_W-1:0] readCnt;
      logic             pending;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          readCnt <= '0;
          pending <= 1'b0;
        end else if (selChange) begin
          readCnt <= '0;
          pending <= 1'b1;
        end else if (pending && rdStrobe) begin
          if (readCnt == CNT_W'(SETTLE_READS - 2)) pending <= 1'b0;
          else readCnt <= readCnt + 1'b1;
        end
      end

      assign showLoad = pending && rdStrobe && !selChange &&
                        (readCnt == CNT_W'(SETTLE_READS - 2));
    end
  endgenerate

  always_comb begin
    strobes.showLoad = showLoad;
    for (int d = 0; d < NUM_DRIVES; d++)
      strobes.moveHit[d] = moveDone && moveOk && (moveDrive == SEL_W'(d));
  end
endmodule

// File: rtl/dc_datapath.sv
module dc_datapath
  import dc_pkg::*;
#(
  parameter int CYL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dcStrobe_t             strobes,
  input  logic [NUM_DRIVES-1:0] doorEvt,
  input  logic [SEL_W-1:0]      selDrive,
  input  logic [NUM_DRIVES-1:0] motorEn,
  input  logic                  moveIsRecal,
  input  logic [CYL_W-1:0]      moveCyl,
  output logic [NUM_DRIVES-1:0] chgFlags,
  output logic [SEL_W-1:0]      shownDrive,
  output logic [7:0]            dirByte
);
  logic [CYL_W-1:0] target;
  assign target = moveIsRecal ? '0 : moveCyl;

  generate
    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
      logic [CYL_W-1:0] presCyl;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chgFlags[d] <= 1'b0;
          presCyl     <= '0;
        end else begin
          if (doorEvt[d])
            chgFlags[d] <= 1'b1;
          else if (strobes.moveHit[d] && (target != presCyl))
            chgFlags[d] <= 1'b0;
          if (strobes.moveHit[d]) presCyl <= target;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shownDrive <= '0;
    else if (strobes.showLoad) shownDrive <= selDrive;
  end

  assign dirByte = {motorEn[selDrive] & chgFlags[shownDrive], 7'b0};
endmodule

// File: rtl/disk_change_tracker.sv
module disk_change_tracker
  import dc_pkg::*;
#(
  parameter int CYL_W        = 8,
  parameter int SETTLE_READS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       doorEvt,
  input  logic [1:0]       selDrive,
  input  logic [3:0]       motorEn,
  input  logic             rdStrobe,
  input  logic             moveDone,
  input  logic [1:0]       moveDrive,
  input  logic             moveIsRecal,
  input  logic [CYL_W-1:0] moveCyl,
  input  logic             moveOk,
  output logic [7:0]       dirByte
);
  dcStrobe_t             strobes;
  logic [NUM_DRIVES-1:0] chgFlags;
  logic [SEL_W-1:0]      shownDrive;

  dc_ctrl #(.SETTLE_READS(SETTLE_READS)) u_ctrl (
    .clk(clk), .rstN(rstN), .selDrive(selDrive), .rdStrobe(rdStrobe),
    .moveDone(moveDone), .moveDrive(moveDrive), .moveOk(moveOk),
    .strobes(strobes)
  );

  dc_datapath #(.CYL_W(CYL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .doorEvt(doorEvt),
    .selDrive(selDrive), .motorEn(motorEn), .moveIsRecal(moveIsRecal),
    .moveCyl(moveCyl), .chgFlags(chgFlags), .shownDrive(shownDrive),
    .dirByte(dirByte)
  );
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int SETTLE_READS = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] doorEvt,
  input logic [1:0] selDrive,
  input logic [3:0] motorEn,
  input logic       rdStrobe,
  input logic       moveDone,
  input logic       moveOk,
  input logic [3:0] chgFlags,
  input logic [1:0] shownDrive,
  input logic [7:0] dirByte
);
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    dirByte[6:0] == 7'b0);  // R1

  AST_DOOR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (doorEvt != 4'b0) |=> ((chgFlags & $past(doorEvt)) == $past(doorEvt)));  // R2

  AST_FAILED_MOVE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (moveDone && !moveOk) |=> (($past(chgFlags) & ~chgFlags) == 4'b0));  // R6

  AST_ONLY_MOVE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !moveDone |=> (($past(chgFlags) & ~chgFlags) == 4'b0));  // R3

  AST_MOTOR_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !motorEn[selDrive] |-> !dirByte[7]);  // R8

  generate
    if (SETTLE_READS > 1) begin : g_settle_chk
      AST_SHOW_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
        !rdStrobe |=> $stable(shownDrive));  // R9
    end
  endgenerate
endmodule

bind disk_change_tracker dc_checker #(.SETTLE_READS(SETTLE_READS)) u_chk (
  .clk(clk), .rstN(rstN), .doorEvt(doorEvt), .selDrive(selDrive),
  .motorEn(motorEn), .rdStrobe(rdStrobe), .moveDone(moveDone),
  .moveOk(moveOk), .chgFlags(chgFlags), .shownDrive(shownDrive),
  .dirByte(dirByte)
);

// File: tb/sim_disk_change_tracker.sv
`timescale 1ns/1ps
module sim_disk_change_tracker;
  localparam int CYL_W  = 3;
  localparam int SETTLE = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       doorEvt = '0;
  logic [1:0]       selDrive = '0;
  logic [3:0]       motorEn = 4'hF;
  logic             rdStrobe = 1'b0;
  logic             moveDone = 1'b0;
  logic [1:0]       moveDrive = '0;
  logic             moveIsRecal = 1'b0;
  logic [CYL_W-1:0] moveCyl = '0;
  logic             moveOk = 1'b0;
  logic [7:0]       dirByte;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit             expChg [4];
  int unsigned    expCyl [4];

  always #4 clk = ~clk;

  disk_change_tracker #(.CYL_W(CYL_W), .SETTLE_READS(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .doorEvt(doorEvt), .selDrive(selDrive),
    .motorEn(motorEn), .rdStrobe(rdStrobe), .moveDone(moveDone),
    .moveDrive(moveDrive), .moveIsRecal(moveIsRecal), .moveCyl(moveCyl),
    .moveOk(moveOk), .dirByte(dirByte)
  );

  task automatic doRead(output logic [7:0] got);
    rdStrobe = 1'b1;
    #2 got = dirByte;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic readChk(string req, bit expBit);
    logic [7:0] got;
    doRead(got);
    checks++;
    if (got !== {expBit, 7'b0}) begin
      fails++;
      $display("FAIL %s: dirByte actual=%02h expected=%02h", req, got, {expBit, 7'b0});
    end
  endtask

  task automatic selectDrive(int d);
    logic [7:0] got;
    selDrive = 2'(d);
    @(negedge clk);
    for (int i = 0; i < SETTLE; i++) doRead(got);
  endtask

  task automatic pulse(bit doDoor, bit doMove, int d, bit recal, int cyl, bit ok);
    if (doDoor) doorEvt[d] = 1'b1;
    if (doMove) begin
      moveDone = 1'b1; moveDrive = 2'(d); moveIsRecal = recal;
      moveCyl = CYL_W'(cyl); moveOk = ok;
    end
    @(negedge clk);
    doorEvt = '0; moveDone = 1'b0; moveOk = 1'b0; moveIsRecal = 1'b0;
    if (doMove && ok) begin
      int unsigned tgt = recal ? 0 : cyl;
      if (tgt != expCyl[d]) expChg[d] = 0;
      expCyl[d] = tgt;
    end
    if (doDoor) expChg[d] = 1;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    selDrive = '0;
    for (int d = 0; d < 4; d++) begin expChg[d] = 0; expCyl[d] = 0; end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    applyReset();
    // R10: all flags clear after reset
    for (int d = 0; d < 4; d++) begin
      selectDrive(d);
      readChk("R10 reset flag", 1'b0);
    end

    // Sweep: every drive, both movement kinds, every cylinder, both outcomes
    for (int d = 0; d < 4; d++) begin
      selectDrive(d);
      for (int recal = 0; recal < 2; recal++) begin
        for (int c = 0; c < 8; c++) begin
          for (int ok = 0; ok < 2; ok++) begin
            string tag;
            int unsigned tgt = (recal != 0) ? 0 : c;
            if ((c + ok + recal) % 3 != 0) pulse(1, 0, d, 0, 0, 0);
            if (ok == 0)               tag = "R6 failed move";
            else if (recal != 0)       tag = "R5 recalibrate";
            else if (tgt == expCyl[d]) tag = "R4 same-cylinder seek";
            else                       tag = "R3 new-cylinder seek";
            pulse(0, 1, d, recal[0], c, ok[0]);
            readChk(tag, expChg[d]);
          end
        end
      end
      // R2 door event alone sets flag
      pulse(1, 0, d, 0, 0, 0);
      readChk("R2 door sets", 1'b1);
      // R2 door wins over a clearing seek in the same cycle
      pulse(1, 1, d, 0, (expCyl[d] + 1) % 8, 1);
      readChk("R2 door priority", 1'b1);
      if (d < 3) begin
        pulse(0, 1, d, 0, (expCyl[d] + 3) % 8, 1);
        readChk("R3 clear before next drive", 1'b0);
      end
    end

    // R7: other drives keep their own state
    for (int d = 0; d < 4; d++) begin
      selectDrive(d);
      readChk("R7 per-drive isolation", expChg[d]);
    end

    // R8: motor off gates the bit
    selectDrive(3);
    motorEn = 4'b0111;
    readChk("R8 motor off", 1'b0);
    motorEn = 4'b1000;
    readChk("R8 only selected motor matters", 1'b1);
    motorEn = 4'hF;

    // R9: settling window
    selectDrive(0);
    readChk("R9 drive0 clear", 1'b0);
    selDrive = 2'd3;
    @(negedge clk);
    for (int i = 1; i < SETTLE; i++) readChk("R9 stale read", 1'b0);
    readChk("R9 settled read", 1'b1);
    readChk("R9 stays settled", 1'b1);

    // R10: mid-run reset clears flags and cylinders
    selectDrive(1);
    pulse(0, 1, 1, 0, 5, 1);
    applyReset();
    readChk("R10 flag after reset", 1'b0);
    pulse(1, 0, 1, 0, 0, 0);
    selectDrive(1);
    pulse(0, 1, 1, 0, 0, 1);
    readChk("R10 cylinder zero after reset (R4)", 1'b1);
    pulse(0, 1, 1, 1, 6, 1);
    readChk("R5 recal at cylinder 0 keeps flag", 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule